// File: doc/BRIEF.md
# BCD Time-of-Day Counter

This block keeps a 24-hour time of day as three packed two-digit BCD fields: hours, minutes and seconds. A one-second enable is derived inside the block by counting cycles of the system clock (50,000,000 cycles at the default setting). Each field advances only when the field below it wraps. Every carry is a single-cycle enable in the system clock domain, never a derived clock.

A pause input freezes both the sub-second count and the fields, so no time is lost. A preset port loads a BCD byte into one chosen field. A byte that is not valid BCD, or that is beyond the field's range, is dropped. A clear input resets everything asynchronously.

The 24-bit time word is laid out so that a multiplexed seven-segment formatter can take its digits directly.

Top module: `bcd_tod_clock`

## Requirements
- R1: While `rst_n` is low, `time_o` is 0 and all three carry outputs are 0, with no clock edge needed. After `rst_n` rises, the first two rising edges only release the internal reset. Counting starts on the third edge.
- R2: When not paused, the block raises an internal one-second tick once every `TICKS_PER_SEC` cycles. With `TICKS_PER_SEC`=3 after a reset release, seconds reads 00 after the fourth edge and 01 after the fifth edge.
- R3: Every field stores its tens digit in bits [7:4] and its units digit in bits [3:0]. When a field increments from units 9, it reads units 0 with the tens digit raised by one (for example, 09 becomes 10).
- R4: Seconds wraps from 59 to 00 and advances minutes on the same edge. `sec_carry_o` is high only during the cycle whose closing edge performs that wrap.
- R5: Minutes wraps from 59 to 00 when the seconds carry arrives. That edge advances hours, and `min_carry_o` is high only in that cycle.
- R6: From 23:59:59 the next tick gives 00:00:00. `day_carry_o` is high only in the cycle that ends in this wrap.
- R7: While `pause_i` is 1, neither the sub-second count nor any field changes. After release, the next tick arrives after the remaining count only.
- R8: With `preset_en_i`=1, the edge loads `preset_val_i` into one field chosen by `preset_sel_i`: 0 = seconds, 1 = minutes, 2 = hours. Select code 3 loads nothing. A load takes priority over that field's increment on the same edge and suppresses that field's carry.
- R9: A preset byte is ignored, and the field keeps its value, if either nibble is above 9 or if the value is above 59 (seconds, minutes) or above 23 (hours).
- R10: `time_o` carries hours in [23:16], minutes in [15:8] and seconds in [7:0].
- R11: Presets take effect while paused, and the paused fields stay frozen afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| pause_i | input | 1 | 1 freezes timekeeping |
| preset_en_i | input | 1 | Load strobe for the preset |
| preset_sel_i | input | 2 | Field select: 0 sec, 1 min, 2 hr, 3 none |
| preset_val_i | input | 8 | Packed BCD value to load |
| time_o | output | 24 | Packed BCD hours, minutes, seconds |
| sec_carry_o | output | 1 | Seconds wrap enable |
| min_carry_o | output | 1 | Minutes wrap enable |
| day_carry_o | output | 1 | Day wrap enable |

## Verification
The bench builds the block with `TICKS_PER_SEC` set to 3. With that setting a second passes in three cycles, so the exact cycle of each tick and of a pause-resume can be checked by hand.

Day, hour and minute boundaries are reached by presetting the fields near them rather than by running a full day. The default divider cannot be covered in a short run; only its bound assertion applies there.

// File: rtl/tod_pkg.sv
package tod_pkg;

  typedef enum logic [1:0] {
    SEL_SEC  = 2'd0,
    SEL_MIN  = 2'd1,
    SEL_HR   = 2'd2,
    SEL_NONE = 2'd3
  } field_sel_e;

  // True when both nibbles are decimal digits and the value does not exceed lim.
  function automatic logic bcd_ok(input logic [7:0] v, input logic [7:0] lim);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v <= lim);
  endfunction

endpackage

// File: rtl/tod_rst_sync.sv
module tod_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic stage_q, out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_s_n = out_q;
endmodule

// File: rtl/tod_tick_div.sv
module tod_tick_div #(
  parameter int unsigned DIV = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pause_i,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_passthru
      assign tick_o = rst_n && !pause_i;
    end else begin : g_count
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q, cnt_d;
      logic          at_last;

      assign at_last = (cnt_q == LAST);

      always_comb begin
        cnt_d = cnt_q;
        if (!pause_i) cnt_d = at_last ? '0 : cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick_o = at_last && !pause_i;

      a_r7_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
        pause_i |=> $stable(cnt_q));
      a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    end
  endgenerate
endmodule

// File: rtl/tod_bcd_field.sv
module tod_bcd_field
  import tod_pkg::*;
#(
  parameter logic [7:0] MAX_VAL = 8'h59
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc_i,
  input  logic       ld_i,
  input  logic [7:0] ld_val_i,
  output logic [7:0] value_o,
  output logic       carry_o
);
  logic [7:0] val_q, val_d, val_inc;
  logic       ld_ok, at_max;

  assign ld_ok  = ld_i && bcd_ok(ld_val_i, MAX_VAL);
  assign at_max = (val_q == MAX_VAL);

  always_comb begin
    if (at_max)                val_inc = 8'h00;
    else if (val_q[3:0] == 4'd9) val_inc = {val_q[7:4] + 4'd1, 4'd0};
    else                       val_inc = {val_q[7:4], val_q[3:0] + 4'd1};
  end

  always_comb begin
    val_d = val_q;
    if (ld_ok)      val_d = ld_val_i;
    else if (inc_i) val_d = val_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= 8'h00;
    else        val_q <= val_d;
  end

  assign carry_o = inc_i && at_max && !ld_ok;
  assign value_o = val_q;

  a_r3_digits_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (val_q[3:0] <= 4'd9) && (val_q <= MAX_VAL));
  a_r4_carry_clears: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |=> (val_q == 8'h00));
  a_r9_bad_preset_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_i && !bcd_ok(ld_val_i, MAX_VAL) && !inc_i) |=> $stable(val_q));
endmodule

// File: rtl/bcd_tod_clock.sv
module bcd_tod_clock
  import tod_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 50_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pause_i,
  input  logic        preset_en_i,
  input  logic [1:0]  preset_sel_i,
  input  logic [7:0]  preset_val_i,
  output logic [23:0] time_o,
  output logic        sec_carry_o,
  output logic        min_carry_o,
  output logic        day_carry_o
);
  localparam int NFIELD = 3;
  localparam logic [7:0] LIMITS [NFIELD] = '{8'h59, 8'h59, 8'h23};

  logic rst_s_n, tick;
  logic [NFIELD-1:0] inc_vec, carry_vec, ld_vec;
  logic [7:0]        fval [NFIELD];

  tod_rst_sync u_sync (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  tod_tick_div #(.DIV(TICKS_PER_SEC)) u_div (
    .clk(clk), .rst_n(rst_s_n), .pause_i(pause_i), .tick_o(tick)
  );

  assign inc_vec = {carry_vec[1:0], tick};

  generate
    for (genvar i = 0; i < NFIELD; i++) begin : g_field
      assign ld_vec[i] = preset_en_i && (preset_sel_i == 2'(i));
      tod_bcd_field #(.MAX_VAL(LIMITS[i])) u_fld (
        .clk(clk), .rst_n(rst_s_n), .inc_i(inc_vec[i]),
        .ld_i(ld_vec[i]), .ld_val_i(preset_val_i),
        .value_o(fval[i]), .carry_o(carry_vec[i])
      );
    end
  endgenerate

  assign time_o      = {fval[2], fval[1], fval[0]};
  assign sec_carry_o = carry_vec[0];
  assign min_carry_o = carry_vec[1];
  assign day_carry_o = carry_vec[2];

  a_r6_day_wrap: assert property (@(posedge clk) disable iff (!rst_s_n)
    day_carry_o |=> (time_o == 24'h000000));
  a_r5_min_needs_sec: assert property (@(posedge clk) disable iff (!rst_s_n)
    min_carry_o |-> sec_carry_o);
  a_r1_clear_zero: assert property (@(posedge clk)
    !rst_n |-> (time_o == 24'h0 && !sec_carry_o && !min_carry_o && !day_carry_o));
endmodule

// File: tb/tb_bcd_tod_clock.sv
module tb_bcd_tod_clock;
  localparam int DIV = 3;

  logic clk = 1'b0, rst_n = 1'b0, pause = 1'b0, pen = 1'b0;
  logic [1:0]  psel = 2'd3;
  logic [7:0]  pval = 8'h00;
  logic [23:0] time_o;
  logic sc, mc, dc;
  int checks = 0, errors = 0, day_pulses = 0, min_pulses = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  bcd_tod_clock #(.TICKS_PER_SEC(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .pause_i(pause), .preset_en_i(pen),
    .preset_sel_i(psel), .preset_val_i(pval), .time_o(time_o),
    .sec_carry_o(sc), .min_carry_o(mc), .day_carry_o(dc)
  );

  // Behavioural reference: integer time and divider phase
  int m_s, m_m, m_h, m_c, m_rel;

  function automatic int b2i(logic [7:0] b); return b[7:4] * 10 + b[3:0]; endfunction
  function automatic logic [7:0] i2b(int v); return 8'((v / 10) * 16 + (v % 10)); endfunction
  function automatic bit okv(logic [7:0] b, int lim);
    return b[3:0] <= 9 && b[7:4] <= 9 && b2i(b) <= lim;
  endfunction
  function automatic bit ld(int f);
    int lim = (f == 2) ? 23 : 59;
    return pen && psel == 2'(f) && okv(pval, lim);
  endfunction
  function automatic bit m_tick(); return m_rel == 2 && !pause && m_c == DIV - 1; endfunction
  function automatic bit m_cs(); return m_tick() && !ld(0) && m_s == 59; endfunction
  function automatic bit m_cm(); return m_cs() && !ld(1) && m_m == 59; endfunction
  function automatic bit m_ch(); return m_cm() && !ld(2) && m_h == 23; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s = 0; m_m = 0; m_h = 0; m_c = 0; m_rel = 0;
    end else begin
      if (m_rel == 2) begin
        bit t, cs, cm;
        t = m_tick(); cs = m_cs(); cm = m_cm();
        if (ld(2)) m_h = b2i(pval); else if (cm) m_h = (m_h + 1) % 24;
        if (ld(1)) m_m = b2i(pval); else if (cs) m_m = (m_m + 1) % 60;
        if (ld(0)) m_s = b2i(pval); else if (t)  m_s = (m_s + 1) % 60;
        if (!pause) m_c = (m_c + 1) % DIV;
      end
      if (m_rel < 2) m_rel++;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the reference (R10 packing, R4 R5 R6 carries)
  always @(negedge clk) if (!done) begin
    chk("R10 time word", {8'h0, time_o}, {8'h0, i2b(m_h), i2b(m_m), i2b(m_s)});
    chk("R4 sec carry", {31'h0, sc}, {31'h0, m_cs()});
    chk("R5 min carry", {31'h0, mc}, {31'h0, m_cm()});
    chk("R6 day carry", {31'h0, dc}, {31'h0, m_ch()});
    if (dc) day_pulses++;
    if (mc) min_pulses++;
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask
  task automatic preset(logic [1:0] s, logic [7:0] v);
    pen = 1'b1; psel = s; pval = v;
    cyc(1);
    pen = 1'b0; psel = 2'd3;
  endtask
  task automatic snap(output logic [23:0] v);
    @(negedge clk); v = time_o; cyc(1);
  endtask

  initial begin
    logic [23:0] t0, t1;
    cyc(3);
    @(negedge clk);
    chk("R1 clear time", {8'h0, time_o}, 32'h0);
    chk("R1 clear carries", {29'h0, sc, mc, dc}, 32'h0);
    rst_n = 1'b1;
    cyc(4);
    @(negedge clk); chk("R2 no tick after 4 edges", {24'h0, time_o[7:0]}, 32'h00);
    cyc(1);
    @(negedge clk); chk("R2 tick after 5 edges", {24'h0, time_o[7:0]}, 32'h01);
    cyc(30);
    @(negedge clk); chk("R3 tens digit advanced", {24'h0, time_o[7:0]}, 32'h11);
    // R7 pause
    pause = 1'b1; cyc(1);
    snap(t0); cyc(10); snap(t1);
    chk("R7 pause holds", {8'h0, t1}, {8'h0, t0});
    pause = 1'b0; cyc(9);
    // R11 / R8 preset while paused, then R6 wrap
    pause = 1'b1;
    preset(2'd2, 8'h23); preset(2'd1, 8'h59); preset(2'd0, 8'h58);
    snap(t0);
    chk("R11 preset while paused", {8'h0, t0}, 32'h00235958);
    cyc(5); snap(t1);
    chk("R11 frozen after preset", {8'h0, t1}, 32'h00235958);
    pause = 1'b0; cyc(8);
    @(negedge clk);
    chk("R6 day wrap count", day_pulses, 1);
    chk("R6 wrapped hours/minutes", {16'h0, time_o[23:8]}, 32'h0);
    // R9 invalid presets, R8 select 3
    pause = 1'b1; cyc(1);
    snap(t0);
    preset(2'd0, 8'h5A); preset(2'd0, 8'h60); preset(2'd1, 8'hA1);
    preset(2'd2, 8'h24); preset(2'd3, 8'h12);
    snap(t1);
    chk("R9 bad presets ignored", {8'h0, t1}, {8'h0, t0});
    chk("R8 select 3 loads nothing", {8'h0, t1}, {8'h0, t0});
    preset(2'd2, 8'h09);
    snap(t1); chk("R8 hours load", {24'h0, t1[23:16]}, 32'h09);
    // R5 minute wrap into hour
    preset(2'd1, 8'h59); preset(2'd0, 8'h57);
    pause = 1'b0; cyc(12);
    @(negedge clk);
    chk("R5 minute wraps once", min_pulses, 2);
    chk("R5 hour advanced", {24'h0, time_o[23:16]}, 32'h10);
    // R8 preset beats tick on same edge: load seconds on every edge for a while
    pen = 1'b1; psel = 2'd0; pval = 8'h30; cyc(6); pen = 1'b0; psel = 2'd3;
    @(negedge clk); chk("R8 preset wins", {24'h0, time_o[7:0]}, 32'h30);
    // R1 async clear mid-run
    cyc(7); #1 rst_n = 1'b0; #1;
    chk("R1 async clear", {8'h0, time_o}, 32'h0);
    cyc(2); rst_n = 1'b1; cyc(20);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    errors++;
    done = 1'b1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule